// File: doc/BRIEF.md
# Iterative Left-Shift Normalizer

This block takes an 11-bit word and moves its highest set bit up into the top position, filling the vacated low bits with zeros. It is purely combinational. The datapath is a cascade of ten identical one-bit stages. Each stage looks only at the top bit of the word it receives. If that bit is already 1, the stage passes the word through unchanged. If it is 0, the stage shifts the word left by one.

Alongside the normalized word, the block reports how far the word moved, as a 4-bit shift count, and raises a flag when the input holds no set bit at all. It suits mantissa alignment or priority scaling paths that tolerate a ten-multiplexer-deep combinational path.

Top module: `lsh_normalizer`

## Requirements
- R1: The output word `norm_out` equals `word_in` shifted left by the number of leading zeros of `word_in`, with zeros entering at bit 0.
- R2: For every nonzero input, bit 10 of `norm_out` is 1.
- R3: For every nonzero input, shifting `norm_out` right by `shift_amt` gives back `word_in` exactly, so no set bit is lost.
- R4: An all-zero input produces an all-zero `norm_out`.
- R5: `all_zero` is 1 exactly when `word_in` is all zeros, and `shift_amt` is 0 in that case.
- R6: An input with bit 10 set, which includes every negative two's-complement value, appears on `norm_out` unchanged with `shift_amt` equal to 0.
- R7: For a nonzero input, `shift_amt` (4 bits, unsigned) equals the count of leading zeros, in the range 0 to 10.
- R8: Each stage passes its word when that word's top bit is 1, and otherwise shifts it left by one with a 0 fill. Ten such stages normalize even the input 1, which becomes 0x400 with `shift_amt` equal to 10.
- R9: The block holds no state. The outputs follow a change of `word_in` with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | 11 | Word to be normalized |
| norm_out | output | 11 | Normalized word, highest set bit at bit 10 |
| shift_amt | output | 4 | Number of positions shifted (leading-zero count) |
| all_zero | output | 1 | 1 when the input has no set bit |

## Verification
The embedded checks assume that `word_in` carries known 0/1 values. They skip evaluation whenever the input holds X or Z, which covers the interval before the bench first drives it. The stimulus drives every value from 0 to 2047 once, with a fully defined word each time, and holds each value for a whole cycle so the outputs are settled before sampling. Because the input space is covered exhaustively, the zero word, the words with bit 10 already set and the single-bit word 1 are all included.

// File: rtl/lsh_norm_pkg.sv
package lsh_norm_pkg;
  parameter int unsigned NORM_WIDTH_DEF = 11;

  function automatic int unsigned cnt_width(input int unsigned w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/lsh_word_mux.sv
module lsh_word_mux #(
  parameter int unsigned W = 11
) (
  input  logic         sel,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] y
);
  // sel = 0 picks in_a, sel = 1 picks in_b
  always_comb begin
    y = sel ? in_b : in_a;
  end
endmodule

// File: rtl/lsh_cond_stage.sv
module lsh_cond_stage #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] stg_in,
  output logic [W-1:0] stg_out,
  output logic         stg_moved
);
  logic [W-1:0] shifted_w;

  assign shifted_w = {stg_in[W-2:0], 1'b0};
  assign stg_moved = ~stg_in[W-1];

  lsh_word_mux #(.W(W)) u_mux (
    .sel  (stg_moved),
    .in_a (stg_in),
    .in_b (shifted_w),
    .y    (stg_out)
  );

  always_comb begin
    if (!$isunknown(stg_in)) begin
      AST_STAGE_KEEP: assert (!stg_in[W-1] || (stg_out == stg_in))
        else $error("stage altered a word with top bit set"); // R8
      AST_STAGE_FILL: assert (stg_in[W-1] || (stg_out[0] == 1'b0))
        else $error("stage shift did not fill with zero"); // R8
    end
  end
endmodule

// File: rtl/lsh_normalizer.sv
module lsh_normalizer
  import lsh_norm_pkg::*;
#(
  parameter int unsigned WIDTH = NORM_WIDTH_DEF,
  localparam int unsigned CNT_W = cnt_width(WIDTH)
) (
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] norm_out,
  output logic [CNT_W-1:0] shift_amt,
  output logic             all_zero
);
  localparam int unsigned N_STG = WIDTH - 1;

  logic [WIDTH-1:0] chain [0:N_STG];
  logic [N_STG-1:0] moved;
  logic [CNT_W-1:0] moved_sum;

  assign chain[0] = word_in;

  generate
    for (genvar gi = 0; gi < N_STG; gi++) begin : g_stage
      lsh_cond_stage #(.W(WIDTH)) u_stage (
        .stg_in    (chain[gi]),
        .stg_out   (chain[gi+1]),
        .stg_moved (moved[gi])
      );
    end
  endgenerate

  // count of stages that shifted
  always_comb begin
    moved_sum = '0;
    for (int i = 0; i < int'(N_STG); i++) begin
      moved_sum = moved_sum + CNT_W'(moved[i]);
    end
  end

  // after the chain, a clear top bit can only mean an empty input
  assign all_zero  = ~chain[N_STG][WIDTH-1];
  assign norm_out  = chain[N_STG];
  assign shift_amt = all_zero ? '0 : moved_sum;

  always_comb begin
    if (!$isunknown(word_in)) begin
      AST_ZERO_MATCH: assert (all_zero == (word_in == '0))
        else $error("zero flag disagrees with input"); // R5
      AST_ZERO_OUT: assert (!all_zero || ((norm_out == '0) && (shift_amt == '0)))
        else $error("zero input gave nonzero result"); // R4
      AST_TOP_SET: assert (all_zero || norm_out[WIDTH-1])
        else $error("nonzero result lacks top bit"); // R2
      AST_LOSSLESS: assert (all_zero || ((norm_out >> shift_amt) == word_in))
        else $error("set bits lost in normalization"); // R3
      AST_PASS_THRU: assert (!word_in[WIDTH-1] || ((norm_out == word_in) && (shift_amt == '0)))
        else $error("already-normalized input altered"); // R6
    end
  end
endmodule

// File: tb/tb_lsh_normalizer.sv
`timescale 1ns/1ps
module tb_lsh_normalizer;
  localparam int W = 11;
  localparam int CW = 4;

  typedef struct {
    logic [W-1:0]  vin;
    logic [W-1:0]  e_out;
    logic [CW-1:0] e_cnt;
    logic          e_zero;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]  word_in;
  logic [W-1:0]  norm_out;
  logic [CW-1:0] shift_amt;
  logic          all_zero;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  lsh_normalizer dut (
    .word_in   (word_in),
    .norm_out  (norm_out),
    .shift_amt (shift_amt),
    .all_zero  (all_zero)
  );

  function automatic item_t ref_model(input logic [W-1:0] v);
    item_t it;
    logic [W-1:0] w;
    int n;
    w = v;
    n = 0;
    if (v != '0) begin
      while (w[W-1] == 1'b0) begin
        w = w << 1;
        n++;
      end
    end
    it.vin = v;
    it.e_out = w;
    it.e_cnt = CW'(n);
    it.e_zero = (v == '0);
    return it;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] v);
    @(posedge clk);
    #1;
    word_in = v;
    sb_q.push_back(ref_model(v));
  endtask

  // monitor: sample mid-cycle, away from edges
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(norm_out == it.e_out, "R1", "word", int'(norm_out), int'(it.e_out));
      check(all_zero == it.e_zero, "R5", "zero flag", int'(all_zero), int'(it.e_zero));
      if (it.vin != '0)
        check(shift_amt == it.e_cnt, "R7", "count", int'(shift_amt), int'(it.e_cnt));
      else begin
        check(shift_amt == '0, "R5", "count on zero", int'(shift_amt), 0);
        check(norm_out == '0, "R4", "zero word", int'(norm_out), 0);
      end
      if (it.vin != '0) begin
        check(norm_out[W-1] == 1'b1, "R2", "top bit", int'(norm_out[W-1]), 1);
        check((norm_out >> shift_amt) == it.vin, "R3", "restore",
              int'(norm_out >> shift_amt), int'(it.vin));
      end
      if (it.vin[W-1])
        check(norm_out == it.vin && shift_amt == '0, "R6", "pass-through",
              int'(norm_out), int'(it.vin));
      if (it.vin == 11'd1)
        check(norm_out == 11'h400 && shift_amt == 4'd10, "R8", "full chain count",
              int'(shift_amt), 10);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    word_in = '0;
    repeat (3) @(posedge clk);
    #2;
    check(norm_out == '0 && all_zero == 1'b1, "R4", "reset-time zero",
          int'(norm_out), 0);
    rst_n = 1'b1;
    for (int v = 0; v < (1 << W); v++) drive(W'(v));
    @(posedge clk);
    #1;
    while (sb_q.size() > 0) @(negedge clk);
    #2;
    // no clock edge between change and sample
    word_in = 11'h013;
    #1;
    check(norm_out == 11'h4C0 && shift_amt == 4'd6, "R9", "comb response",
          int'(norm_out), 'h4C0);
    word_in = 11'h7FF;
    #1;
    check(norm_out == 11'h7FF && shift_amt == 4'd0, "R9", "comb response 2",
          int'(norm_out), 'h7FF);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule